// File: doc/BRIEF.md
# Double-Buffered Timer Compare Channel

This block is one 16-bit compare channel beside a timer/counter. Every clock it checks the whole counter value, supplied from outside, against an active compare register. On equality it sets a sticky match flag, which raises an interrupt request. It also sends a one-cycle clear pulse back to the counter and changes a waveform pin according to a 2-bit action field. The counter, the mode decoder and the bus interface all sit outside the block.

While the external mode logic reports a PWM mode, software writes land in a shadow buffer. The active register takes the buffer value only at the update point, which is the counter's TOP or BOTTOM, chosen by one select input. This keeps the duty cycle from changing in the middle of a period. In the non-PWM modes a write goes straight into the active register. A force strobe, accepted only outside PWM modes, moves the pin the same way a match would. It does not set the flag and does not pulse the counter clear.

Top module: `dbuf_compare_unit`

## Requirements
- R1: While `rstN` is low, and afterwards until the first clock edge, `cmpValue`, `bufValue`, `wavePin`, `matchFlag`, `irqReq` and `timerClr` are all zero.
- R2: When `pwmMode` is 0, a write (`wrEn`=1) loads `wrData` into both `cmpValue` and `bufValue` at the next clock edge.
- R3: When `pwmMode` is 1, a write loads only `bufValue`. `cmpValue` keeps its value unless the edge is an update point.
- R4: An update point is an edge where `pwmMode`=1 and either (`syncAtTop`=1 and `atTop`=1) or (`syncAtTop`=0 and `atBottom`=1). At that edge `cmpValue` takes the buffer value held before the edge. The strobe that was not selected has no effect.
- R5: At an edge where `countVal` equals `cmpValue` in all 16 bits, `matchFlag` is set. `timerClr` is high for the cycle that follows that edge and low after any edge without an equality.
- R6: `actionSel` acts on `wavePin` at a match edge as follows: 00 holds, 01 toggles, 10 drives 0, 11 drives 1. With 00 the pin never changes.
- R7: `forceStrobe` with `pwmMode`=0 applies the `actionSel` action to `wavePin` at that edge. It sets neither `matchFlag` nor `timerClr`. A match and a force at the same edge apply the action only once.
- R8: `forceStrobe` with `pwmMode`=1 has no effect on `wavePin`.
- R9: `matchFlag` stays set until an edge with `flagClr`=1. If a match and `flagClr` fall on the same edge, the flag ends set. `irqReq` always equals `matchFlag`.
- R10: `cmpValue` changes only through a direct write (R2) or an update point (R4). Matches, forces and flag clears never modify it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| countVal | input | 16 | Current counter value |
| pwmMode | input | 1 | 1 while the external mode logic selects a PWM mode |
| syncAtTop | input | 1 | Update point select: 1 means TOP, 0 means BOTTOM |
| atTop | input | 1 | Counter is at TOP this cycle |
| atBottom | input | 1 | Counter is at BOTTOM this cycle |
| wrEn | input | 1 | Software write strobe for the compare value |
| wrData | input | 16 | Compare value to write |
| forceStrobe | input | 1 | Force a compare action (non-PWM modes only) |
| actionSel | input | 2 | Pin action: 00 hold, 01 toggle, 10 clear, 11 set |
| flagClr | input | 1 | Write-one-to-clear for the match flag |
| cmpValue | output | 16 | Active compare register |
| bufValue | output | 16 | Shadow buffer register |
| wavePin | output | 1 | Waveform output pin |
| matchFlag | output | 1 | Sticky compare-match flag |
| irqReq | output | 1 | Interrupt request, equal to the flag |
| timerClr | output | 1 | One-cycle pulse to clear the counter after a real match |

## Verification
A wrong active register shows at the ports one clock after the faulty write or update point, because `cmpValue` is an output. It also shows in the first cycle afterwards where the counter equals the intended value, since the flag and the clear pulse then fail to appear. A pin register that takes the wrong action differs from the expected level in the cycle right after the match or force edge. A wrong flag state shows on `irqReq` at once. The sweep covers every action code against every mode, strobe and write combination, with equal and unequal counts. In this way a mistake in any branch appears within one cycle of the step that reaches it.

// File: rtl/dbuf_cmp_pkg.sv
package dbuf_cmp_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } pinAction_e;

  // strobes from control to datapath
  typedef struct packed {
    logic directWrite;   // write active and buffer together
    logic bufferWrite;   // write shadow only
    logic syncLoad;      // copy shadow into active
    logic applyAction;   // drive pin per action field
    logic realMatch;     // set flag, pulse counter clear
  } cmpStrobes_t;

endpackage

// File: rtl/dbuf_cmp_ctrl.sv
module dbuf_cmp_ctrl
  import dbuf_cmp_pkg::*;
(
  input  logic        pwmMode,
  input  logic        syncAtTop,
  input  logic        atTop,
  input  logic        atBottom,
  input  logic        wrEn,
  input  logic        forceStrobe,
  input  logic        countEq,
  output cmpStrobes_t strobes
);

  logic updatePoint;
  logic forceOk;

  always_comb begin
    updatePoint = syncAtTop ? atTop : atBottom;
    forceOk     = forceStrobe & ~pwmMode;

    strobes.directWrite = wrEn & ~pwmMode;
    strobes.bufferWrite = wrEn & pwmMode;
    strobes.syncLoad    = pwmMode & updatePoint;
    strobes.realMatch   = countEq;
    strobes.applyAction = countEq | forceOk;
  end

endmodule

// File: rtl/dbuf_cmp_datapath.sv
module dbuf_cmp_datapath
  import dbuf_cmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] countVal,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       actionSel,
  input  logic             flagClr,
  input  cmpStrobes_t      strobes,
  output logic             countEq,
  output logic [CNT_W-1:0] cmpValue,
  output logic [CNT_W-1:0] bufValue,
  output logic             wavePin,
  output logic             matchFlag,
  output logic             timerClr
);

  logic [CNT_W-1:0] cmpReg;
  logic [CNT_W-1:0] bufReg;
  logic [CNT_W-1:0] diffBits;
  logic             pinReg;
  logic             flagReg;
  logic             clrReg;
  logic             pinNext;

  // bitwise comparator, full width every cycle
  genvar gi;
  generate
    for (gi = 0; gi < CNT_W; gi++) begin : g_cmpBit
      assign diffBits[gi] = countVal[gi] ^ cmpReg[gi];
    end
  endgenerate
  assign countEq = ~|diffBits;

  always_comb begin
    pinNext = pinReg;
    if (strobes.applyAction) begin
      unique case (pinAction_e'(actionSel))
        ACT_HOLD:   pinNext = pinReg;
        ACT_TOGGLE: pinNext = ~pinReg;
        ACT_CLEAR:  pinNext = 1'b0;
        ACT_SET:    pinNext = 1'b1;
        default:    pinNext = pinReg;
      endcase
    end
  end

  // active and shadow compare registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpReg <= '0;
      bufReg <= '0;
    end else begin
      if (strobes.directWrite) begin
        cmpReg <= wrData;
        bufReg <= wrData;
      end else begin
        if (strobes.syncLoad)    cmpReg <= bufReg;
        if (strobes.bufferWrite) bufReg <= wrData;
      end
    end
  end

  // pin, flag and counter clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinReg  <= 1'b0;
      flagReg <= 1'b0;
      clrReg  <= 1'b0;
    end else begin
      pinReg <= pinNext;
      clrReg <= strobes.realMatch;
      if (strobes.realMatch)  flagReg <= 1'b1;
      else if (flagClr)       flagReg <= 1'b0;
    end
  end

  assign cmpValue  = cmpReg;
  assign bufValue  = bufReg;
  assign wavePin   = pinReg;
  assign matchFlag = flagReg;
  assign timerClr  = clrReg;

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (matchFlag && !flagClr) |=> matchFlag);

  assert_clr_with_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    timerClr |-> matchFlag);

  assert_flag_needs_match_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!matchFlag && (countVal != cmpValue)) |=> (!matchFlag && !timerClr));

  assert_hold_action_R6: assert property (@(posedge clk) disable iff (!rstN)
    (actionSel == 2'b00) |=> $stable(wavePin));

endmodule

// File: rtl/dbuf_compare_unit.sv
module dbuf_compare_unit
  import dbuf_cmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] countVal,
  input  logic             pwmMode,
  input  logic             syncAtTop,
  input  logic             atTop,
  input  logic             atBottom,
  input  logic             wrEn,
  input  logic [CNT_W-1:0] wrData,
  input  logic             forceStrobe,
  input  logic [1:0]       actionSel,
  input  logic             flagClr,
  output logic [CNT_W-1:0] cmpValue,
  output logic [CNT_W-1:0] bufValue,
  output logic             wavePin,
  output logic             matchFlag,
  output logic             irqReq,
  output logic             timerClr
);

  cmpStrobes_t strobes;
  logic        countEq;

  dbuf_cmp_ctrl u_ctrl (
    .pwmMode     (pwmMode),
    .syncAtTop   (syncAtTop),
    .atTop       (atTop),
    .atBottom    (atBottom),
    .wrEn        (wrEn),
    .forceStrobe (forceStrobe),
    .countEq     (countEq),
    .strobes     (strobes)
  );

  dbuf_cmp_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .countVal  (countVal),
    .wrData    (wrData),
    .actionSel (actionSel),
    .flagClr   (flagClr),
    .strobes   (strobes),
    .countEq   (countEq),
    .cmpValue  (cmpValue),
    .bufValue  (bufValue),
    .wavePin   (wavePin),
    .matchFlag (matchFlag),
    .timerClr  (timerClr)
  );

  assign irqReq = matchFlag;

  assert_direct_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!pwmMode && !wrEn) |=> $stable(cmpValue));

  assert_pwm_no_sync_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pwmMode && !atTop && !atBottom) |=> $stable(cmpValue));

  assert_pwm_force_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pwmMode && (countVal != cmpValue)) |=> $stable(wavePin));

endmodule

// File: tb/dbuf_compare_unit_test.sv
`timescale 1ns/1ps
module dbuf_compare_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] countVal = 16'hFFFF;
  logic        pwmMode = 1'b0, syncAtTop = 1'b0, atTop = 1'b0, atBottom = 1'b0;
  logic        wrEn = 1'b0, forceStrobe = 1'b0, flagClr = 1'b0;
  logic [15:0] wrData = '0;
  logic [1:0]  actionSel = 2'b00;
  logic [15:0] cmpValue, bufValue;
  logic        wavePin, matchFlag, irqReq, timerClr;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  // bench model state
  logic [15:0] mCmp = '0, mBuf = '0;
  logic        mPin = 1'b0, mFlag = 1'b0, mClr = 1'b0;

  always #4 clk = ~clk;

  dbuf_compare_unit uut (
    .clk(clk), .rstN(rstN), .countVal(countVal), .pwmMode(pwmMode),
    .syncAtTop(syncAtTop), .atTop(atTop), .atBottom(atBottom),
    .wrEn(wrEn), .wrData(wrData), .forceStrobe(forceStrobe),
    .actionSel(actionSel), .flagClr(flagClr), .cmpValue(cmpValue),
    .bufValue(bufValue), .wavePin(wavePin), .matchFlag(matchFlag),
    .irqReq(irqReq), .timerClr(timerClr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkAll();
    check("R10 cmpValue", 32'(cmpValue), 32'(mCmp));
    check("R3 bufValue", 32'(bufValue), 32'(mBuf));
    check("R6 wavePin", 32'(wavePin), 32'(mPin));
    check("R9 matchFlag", 32'(matchFlag), 32'(mFlag));
    check("R9 irqReq", 32'(irqReq), 32'(mFlag));
    check("R5 timerClr", 32'(timerClr), 32'(mClr));
  endtask

  // inputs are applied at a negedge, outputs compared at the next negedge
  task automatic step(input logic [15:0] cnt, input logic pwm, input logic sync,
                      input logic top, input logic bot, input logic wr,
                      input logic [15:0] wd, input logic frc,
                      input logic [1:0] act, input logic clr);
    logic eq, doAct, upd;
    countVal = cnt; pwmMode = pwm; syncAtTop = sync; atTop = top; atBottom = bot;
    wrEn = wr; wrData = wd; forceStrobe = frc; actionSel = act; flagClr = clr;
    eq    = (cnt == mCmp);
    doAct = eq || (frc && !pwm);
    upd   = pwm && (sync ? top : bot);
    if (doAct) begin
      case (act)
        2'b01: mPin = ~mPin;
        2'b10: mPin = 1'b0;
        2'b11: mPin = 1'b1;
        default: mPin = mPin;
      endcase
    end
    if (eq) mFlag = 1'b1;
    else if (clr) mFlag = 1'b0;
    mClr = eq;
    if (wr && !pwm) begin
      mCmp = wd; mBuf = wd;
    end else begin
      if (upd) mCmp = mBuf;
      if (wr) mBuf = wd;
    end
    @(posedge clk);
    @(negedge clk);
    checkAll();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        finishRun();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 cmpValue", 32'(cmpValue), 0);
    check("R1 bufValue", 32'(bufValue), 0);
    check("R1 wavePin", 32'(wavePin), 0);
    check("R1 matchFlag", 32'(matchFlag), 0);
    check("R1 irqReq", 32'(irqReq), 0);
    check("R1 timerClr", 32'(timerClr), 0);
    rstN = 1'b1;
    check("R1 after release", 32'({cmpValue, wavePin, matchFlag, timerClr}), 0);

    // R2: direct write
    step(16'h0F0F, 0, 0, 0, 0, 1, 16'h1234, 0, 2'b00, 0);
    check("R2 direct cmp", 32'(cmpValue), 32'h1234);
    check("R2 direct buf", 32'(bufValue), 32'h1234);

    // R3: PWM write buffers only
    step(16'h0F0F, 1, 1, 0, 0, 1, 16'hABCD, 0, 2'b00, 0);
    check("R3 cmp held", 32'(cmpValue), 32'h1234);
    check("R3 buf loaded", 32'(bufValue), 32'hABCD);

    // R4: unselected strobe ignored, selected one loads
    step(16'h0F0F, 1, 1, 0, 1, 0, 16'h0, 0, 2'b00, 0);
    check("R4 bottom ignored", 32'(cmpValue), 32'h1234);
    step(16'h0F0F, 1, 1, 1, 0, 0, 16'h0, 0, 2'b00, 0);
    check("R4 top loads", 32'(cmpValue), 32'hABCD);

    // R7: force sets pin, no flag, no clear
    step(16'h0F0F, 0, 0, 0, 0, 0, 16'h0, 1, 2'b11, 0);
    check("R7 force pin", 32'(wavePin), 1);
    check("R7 force no flag", 32'(matchFlag), 0);
    check("R7 force no timerClr", 32'(timerClr), 0);

    // R8: force in PWM ignored
    step(16'h0F0F, 1, 0, 0, 0, 0, 16'h0, 1, 2'b01, 0);
    check("R8 pwm force ignored", 32'(wavePin), 1);

    // R5/R9: real match, then clear
    step(16'hABCD, 0, 0, 0, 0, 0, 16'h0, 0, 2'b10, 0);
    check("R5 flag set", 32'(matchFlag), 1);
    check("R5 timerClr pulse", 32'(timerClr), 1);
    check("R6 clear action", 32'(wavePin), 0);
    step(16'h0F0F, 0, 0, 0, 0, 0, 16'h0, 0, 2'b00, 0);
    check("R5 pulse ends", 32'(timerClr), 0);
    check("R9 flag sticky", 32'(matchFlag), 1);
    step(16'h0F0F, 0, 0, 0, 0, 0, 16'h0, 0, 2'b00, 1);
    check("R9 flag cleared", 32'(irqReq), 0);

    // sweep all control combinations, equal and unequal counts
    for (int k = 0; k < 2048; k++) begin
      logic [10:0] b;
      b = 11'(k);
      step(mCmp + 16'(b[10:9]), b[2], b[3], b[4], b[5], b[8],
           {b[7:0], ~b[7:0]}, b[6], b[1:0], b[7]);
    end

    finishRun();
  end

endmodule